// File: doc/BRIEF.md
# Completion Interrupt Moderator

This block decides, for one completion queue, when the host should be interrupted. Packet completion events arrive as single-cycle pulses, one line for receive and one for transmit. Each direction keeps its own event counter and its own delay timer. The timer advances on a free-running one-microsecond tick. A direction asks for an interrupt when its event count reaches a configured limit, or when its timer has run the configured delay while at least one event is waiting, whichever happens first. Any request from either direction produces one interrupt, and that interrupt clears the moderation state of both directions.

The delay is programmed in units of two microseconds. It runs from the last interrupt, from the last unmask, or from reset. In idle-restart mode every event of that direction restarts its timer, so the delay condition detects a quiet queue, while the count limit still applies. A mask input gives a polling mode. While it is high no interrupt leaves the block, events are still counted, and a condition met during the mask is held and issued as soon as the mask drops. The output pulse stands in for a message-signalled interrupt.

Top module: `irq_moderator`

## Requirements
- R1: With its timer enabled, a direction requests an interrupt once its tick count since the last interrupt, unmask or reset is at least twice the 8-bit delay field and at least one of its events is waiting. Delay values of 1 to 100 give 2 to 200 µs.
- R2: With its count enabled, a direction requests an interrupt as soon as the events counted since the last interrupt reach the 8-bit limit, whatever delay remains. Limits 2 to 128 are honoured, and each event pulse counts as one.
- R3: `irqOut` is high for one clock per firing, on the clock edge after the edge that registered the qualifying event or tick.
- R4: A firing clears the counters and timers of both directions. An event in the firing cycle counts as the first of the new window.
- R5: Receive and transmit have independent configuration and state, and a request from either direction fires the shared output.
- R6: In idle-restart mode every event of a direction restarts that direction's timer, and the count limit still fires.
- R7: While `maskIrq` is high, `irqOut` stays low and events are still counted. A condition met while masked is held and fires when the mask drops, even if it has since gone away.
- R8: The falling edge of `maskIrq` restarts the delay timers of both directions.
- R9: A delay of 0 with the timer enabled gives one interrupt for each event.
- R10: Clearing a direction's timer enable or count enable removes that condition for that direction.
- R11: After reset `irqOut` is low and both directions hold no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle pulse each microsecond |
| rxEvent | input | 1 | Receive completion event pulse |
| txEvent | input | 1 | Transmit completion event pulse |
| maskIrq | input | 1 | High holds interrupts off (polling) |
| rxDelay | input | 8 | Receive delay, 2 µs units |
| rxMaxCount | input | 8 | Receive event limit |
| rxTimerEn | input | 1 | Receive delay condition enable |
| rxCountEn | input | 1 | Receive count condition enable |
| rxIdleMode | input | 1 | Receive timer restarts on each event |
| txDelay | input | 8 | Transmit delay, 2 µs units |
| txMaxCount | input | 8 | Transmit event limit |
| txTimerEn | input | 1 | Transmit delay condition enable |
| txCountEn | input | 1 | Transmit count condition enable |
| txIdleMode | input | 1 | Transmit timer restarts on each event |
| irqOut | output | 1 | Interrupt request pulse |

## Verification
The table runs bursts of back-to-back events followed by counted ticks. The tick counts sit one below and exactly at the delay threshold, and the event counts sit one below, at, and past the limit, so an off-by-one in either condition shows up as a changed interrupt count. Runs that overshoot the limit, or add ticks after a count-triggered firing, show whether a firing clears the timer as well as the counter. Directed sequences alternate events and ticks to separate idle-restart mode from the plain delay. They mix receive and transmit events to show that a firing clears the other direction. They also toggle the mask around met conditions to show that a condition is held while masked and that an unmask restarts the delay.

// File: rtl/irqmod_pkg.sv
package irqmod_pkg;

  localparam int NumDir = 2;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrAll;    // firing: restart both windows
    logic clrTimer;  // unmask: restart delay timers only
  } modStrobe_t;

  // datapath -> control conditions
  typedef struct packed {
    logic timeHit;
    logic countHit;
  } laneHit_t;

endpackage

// File: rtl/irqmod_lane.sv
module irqmod_lane
  import irqmod_pkg::*;
#(
  parameter int DelayW = 8,
  parameter int CountW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              evPulse,
  input  logic [DelayW-1:0] cfgDelay,
  input  logic [CountW-1:0] cfgMaxCount,
  input  logic              cfgTimerEn,
  input  logic              cfgCountEn,
  input  logic              cfgIdleMode,
  input  modStrobe_t        strobe,
  output laneHit_t          hit
);

  localparam int ElapsedW = DelayW + 1;
  localparam logic [ElapsedW-1:0] ElapsedMax = '1;
  localparam logic [CountW-1:0] CountMax = '1;
  localparam logic [CountW-1:0] CountOne = CountW'(1);

  logic [CountW-1:0]   evCount;
  logic [ElapsedW-1:0] elapsed;
  logic [ElapsedW-1:0] target;

  assign target = {cfgDelay, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evCount <= '0;
      elapsed <= '0;
    end else if (strobe.clrAll) begin
      evCount <= evPulse ? CountOne : '0;
      elapsed <= '0;
    end else begin
      if (evPulse && evCount != CountMax) evCount <= evCount + 1'b1;
      if (strobe.clrTimer || (cfgIdleMode && evPulse)) elapsed <= '0;
      else if (usTick && elapsed != ElapsedMax) elapsed <= elapsed + 1'b1;
    end
  end

  always_comb begin
    hit.timeHit  = cfgTimerEn && (evCount != '0) && (elapsed >= target);
    hit.countHit = cfgCountEn && (evCount != '0) && (evCount >= cfgMaxCount);
  end

  AST_CLR_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> evCount <= CountOne); // R4
  AST_COUNT_MONO: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrAll |=> evCount >= $past(evCount)); // R2
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (cfgIdleMode && evPulse) |=> elapsed == '0); // R6
  AST_UNMASK_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrTimer |=> elapsed == '0); // R8

endmodule

// File: rtl/irqmod_ctrl.sv
module irqmod_ctrl
  import irqmod_pkg::*;
#(
  parameter int Lanes = NumDir
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  maskIn,
  input  laneHit_t [Lanes-1:0]  hits,
  output modStrobe_t            strobe,
  output logic                  irqReq
);

  logic anyHit;
  logic fireNow;
  logic maskQ;
  logic pendingQ;

  assign anyHit  = |hits;
  assign fireNow = !maskIn && (anyHit || pendingQ);

  always_comb begin
    strobe.clrAll   = fireNow;
    strobe.clrTimer = maskQ && !maskIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ    <= 1'b0;
      pendingQ <= 1'b0;
      irqReq   <= 1'b0;
    end else begin
      maskQ    <= maskIn;
      irqReq   <= fireNow;
      pendingQ <= fireNow ? 1'b0 : (pendingQ || (maskIn && anyHit));
    end
  end

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    maskIn |=> !irqReq); // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && maskIn) |=> pendingQ); // R7
  AST_FIRE_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !pendingQ); // R4
  AST_HIT_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (!maskIn && anyHit) |=> irqReq); // R5

endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import irqmod_pkg::*;
#(
  parameter int DelayW = 8,
  parameter int CountW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              rxEvent,
  input  logic              txEvent,
  input  logic              maskIrq,
  input  logic [DelayW-1:0] rxDelay,
  input  logic [CountW-1:0] rxMaxCount,
  input  logic              rxTimerEn,
  input  logic              rxCountEn,
  input  logic              rxIdleMode,
  input  logic [DelayW-1:0] txDelay,
  input  logic [CountW-1:0] txMaxCount,
  input  logic              txTimerEn,
  input  logic              txCountEn,
  input  logic              txIdleMode,
  output logic              irqOut
);

  logic [NumDir-1:0]             evVec;
  logic [NumDir-1:0][DelayW-1:0] delayVec;
  logic [NumDir-1:0][CountW-1:0] maxVec;
  logic [NumDir-1:0]             timerEnVec;
  logic [NumDir-1:0]             countEnVec;
  logic [NumDir-1:0]             idleVec;
  laneHit_t [NumDir-1:0]         hitVec;
  modStrobe_t                    strobe;

  always_comb begin
    evVec[DIR_RX]      = rxEvent;
    evVec[DIR_TX]      = txEvent;
    delayVec[DIR_RX]   = rxDelay;
    delayVec[DIR_TX]   = txDelay;
    maxVec[DIR_RX]     = rxMaxCount;
    maxVec[DIR_TX]     = txMaxCount;
    timerEnVec[DIR_RX] = rxTimerEn;
    timerEnVec[DIR_TX] = txTimerEn;
    countEnVec[DIR_RX] = rxCountEn;
    countEnVec[DIR_TX] = txCountEn;
    idleVec[DIR_RX]    = rxIdleMode;
    idleVec[DIR_TX]    = txIdleMode;
  end

  for (genvar d = 0; d < NumDir; d++) begin : g_lane
    irqmod_lane #(.DelayW(DelayW), .CountW(CountW)) u_lane (
      .clk        (clk),
      .rstN       (rstN),
      .usTick     (usTick),
      .evPulse    (evVec[d]),
      .cfgDelay   (delayVec[d]),
      .cfgMaxCount(maxVec[d]),
      .cfgTimerEn (timerEnVec[d]),
      .cfgCountEn (countEnVec[d]),
      .cfgIdleMode(idleVec[d]),
      .strobe     (strobe),
      .hit        (hitVec[d])
    );
  end

  irqmod_ctrl #(.Lanes(NumDir)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .maskIn(maskIrq),
    .hits  (hitVec),
    .strobe(strobe),
    .irqReq(irqOut)
  );

endmodule

// File: tb/sim_irq_moderator.sv
module sim_irq_moderator;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b0, rxEvent = 1'b0, txEvent = 1'b0, maskIrq = 1'b0;
  logic [7:0] rxDelay = '0, rxMaxCount = '0, txDelay = '0, txMaxCount = '0;
  logic rxTimerEn = 1'b0, rxCountEn = 1'b0, rxIdleMode = 1'b0;
  logic txTimerEn = 1'b0, txCountEn = 1'b0, txIdleMode = 1'b0;
  logic irqOut;

  int nChecks = 0, nFails = 0, irqSeen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_moderator u0 (
    .clk(clk), .rstN(rstN), .usTick(usTick), .rxEvent(rxEvent), .txEvent(txEvent),
    .maskIrq(maskIrq), .rxDelay(rxDelay), .rxMaxCount(rxMaxCount),
    .rxTimerEn(rxTimerEn), .rxCountEn(rxCountEn), .rxIdleMode(rxIdleMode),
    .txDelay(txDelay), .txMaxCount(txMaxCount), .txTimerEn(txTimerEn),
    .txCountEn(txCountEn), .txIdleMode(txIdleMode), .irqOut(irqOut)
  );

  always @(negedge clk) if (irqOut === 1'b1) irqSeen++;

  typedef struct packed {
    logic       isTx;
    logic       tEn;
    logic       cEn;
    logic [7:0] dly;
    logic [7:0] maxc;
    logic [7:0] nEv;
    logic [7:0] nTk;
    logic [3:0] expIrq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 8'd3,   8'd100, 8'd1,   8'd5,   4'd0, 4'd1},  // R1 below delay
    '{1'b0, 1'b1, 1'b1, 8'd3,   8'd100, 8'd1,   8'd6,   4'd1, 4'd1},  // R1 at delay
    '{1'b0, 1'b1, 1'b1, 8'd3,   8'd4,   8'd4,   8'd0,   4'd1, 4'd2},  // R2 at limit
    '{1'b0, 1'b1, 1'b1, 8'd3,   8'd4,   8'd3,   8'd0,   4'd0, 4'd2},  // R2 below limit
    '{1'b0, 1'b1, 1'b1, 8'd3,   8'd4,   8'd8,   8'd0,   4'd2, 4'd2},  // R2 two windows
    '{1'b0, 1'b1, 1'b1, 8'd3,   8'd4,   8'd4,   8'd6,   4'd1, 4'd4},  // R4 timer cleared
    '{1'b0, 1'b1, 1'b1, 8'd3,   8'd4,   8'd5,   8'd6,   4'd2, 4'd4},  // R4 fire-cycle event
    '{1'b0, 1'b1, 1'b1, 8'd0,   8'd100, 8'd3,   8'd0,   4'd3, 4'd9},  // R9 zero delay
    '{1'b1, 1'b1, 1'b1, 8'd2,   8'd50,  8'd1,   8'd4,   4'd1, 4'd5},  // R5 tx timer
    '{1'b1, 1'b1, 1'b1, 8'd2,   8'd2,   8'd2,   8'd0,   4'd1, 4'd5},  // R5 tx count
    '{1'b0, 1'b1, 1'b1, 8'd100, 8'd128, 8'd128, 8'd0,   4'd1, 4'd2},  // R2 limit 128
    '{1'b0, 1'b1, 1'b1, 8'd100, 8'd128, 8'd127, 8'd0,   4'd0, 4'd2},  // R2 127 of 128
    '{1'b0, 1'b1, 1'b1, 8'd100, 8'd128, 8'd1,   8'd199, 4'd0, 4'd1},  // R1 199 us
    '{1'b0, 1'b1, 1'b1, 8'd100, 8'd128, 8'd1,   8'd200, 4'd1, 4'd1},  // R1 200 us
    '{1'b0, 1'b0, 1'b1, 8'd1,   8'd100, 8'd1,   8'd10,  4'd0, 4'd10}, // R10 timer off
    '{1'b0, 1'b1, 1'b0, 8'd3,   8'd4,   8'd10,  8'd0,   4'd0, 4'd10}  // R10 count off
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    maskIrq = 1'b0;
    idle(3);
    rstN = 1'b1;
  endtask

  task automatic events(input bit tx, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx) txEvent = 1'b1; else rxEvent = 1'b1;
    end
    @(negedge clk);
    rxEvent = 1'b0;
    txEvent = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) usTick = 1'b1;
      @(negedge clk) usTick = 1'b0;
    end
  endtask

  task automatic cfgRx(input bit tEn, input bit cEn, input int dly, input int mx, input bit idleM);
    rxTimerEn = tEn; rxCountEn = cEn; rxDelay = 8'(dly); rxMaxCount = 8'(mx); rxIdleMode = idleM;
  endtask

  task automatic cfgTx(input bit tEn, input bit cEn, input int dly, input int mx, input bit idleM);
    txTimerEn = tEn; txCountEn = cEn; txDelay = 8'(dly); txMaxCount = 8'(mx); txIdleMode = idleM;
  endtask

  initial begin
    int base;
    doReset();
    idle(2);
    // R11: reset state, and no interrupt from an enabled but idle queue
    cfgRx(1, 1, 0, 2, 0);
    idle(4);
    check("R11", "irq after reset", irqSeen, 0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].isTx) begin
        cfgTx(VEC[v].tEn, VEC[v].cEn, VEC[v].dly, VEC[v].maxc, 0);
        cfgRx(0, 0, 0, 0, 0);
      end else begin
        cfgRx(VEC[v].tEn, VEC[v].cEn, VEC[v].dly, VEC[v].maxc, 0);
        cfgTx(0, 0, 0, 0, 0);
      end
      doReset();
      base = irqSeen;
      events(VEC[v].isTx, int'(VEC[v].nEv));
      idle(2);
      ticks(int'(VEC[v].nTk));
      idle(3);
      check($sformatf("R%0d", VEC[v].req), $sformatf("vector %0d irq count", v),
            irqSeen - base, int'(VEC[v].expIrq));
    end

    // R3: pulse lands on the edge after the limit-reaching event, one clock wide
    cfgTx(0, 0, 0, 0, 0);
    cfgRx(0, 1, 0, 2, 0);
    doReset();
    @(negedge clk) rxEvent = 1'b1;
    @(negedge clk) rxEvent = 1'b1;
    @(negedge clk) rxEvent = 1'b0;
    check("R3", "irq not yet", int'(irqOut), 0);
    @(negedge clk);
    check("R3", "irq high", int'(irqOut), 1);
    @(negedge clk);
    check("R3", "irq one cycle", int'(irqOut), 0);

    // R6: idle-restart delays the timer firing; plain mode fires earlier
    cfgRx(1, 1, 2, 100, 1);
    doReset();
    base = irqSeen;
    events(0, 1); ticks(3); events(0, 1); ticks(3); idle(3);
    check("R6", "idle mode no fire", irqSeen - base, 0);
    ticks(1); idle(3);
    check("R6", "idle mode fires after quiet", irqSeen - base, 1);
    cfgRx(1, 1, 2, 100, 0);
    doReset();
    base = irqSeen;
    events(0, 1); ticks(3); events(0, 1); ticks(1); idle(3);
    check("R1", "plain mode fires from window start", irqSeen - base, 1);
    cfgRx(1, 1, 100, 3, 1);
    doReset();
    base = irqSeen;
    events(0, 3); idle(3);
    check("R6", "count limit in idle mode", irqSeen - base, 1);

    // R5 R4: tx firing clears rx
    cfgRx(0, 1, 0, 4, 0);
    cfgTx(0, 1, 0, 4, 0);
    doReset();
    base = irqSeen;
    events(0, 3); events(1, 4); idle(3);
    check("R5", "tx limit fires", irqSeen - base, 1);
    events(0, 1); idle(3);
    check("R4", "rx cleared by tx fire", irqSeen - base, 1);
    events(0, 3); idle(3);
    check("R4", "rx new window reaches limit", irqSeen - base, 2);
    cfgTx(0, 0, 0, 0, 0);

    // R7: held condition fires on unmask
    cfgRx(0, 1, 0, 4, 0);
    doReset();
    base = irqSeen;
    maskIrq = 1'b1;
    events(0, 4); idle(4);
    check("R7", "masked no irq", irqSeen - base, 0);
    maskIrq = 1'b0; idle(3);
    check("R7", "pending fires on unmask", irqSeen - base, 1);
    // R7: counting continues while masked
    doReset();
    base = irqSeen;
    maskIrq = 1'b1;
    events(0, 3); idle(2);
    maskIrq = 1'b0; idle(3);
    check("R7", "below limit on unmask", irqSeen - base, 0);
    events(0, 1); idle(3);
    check("R7", "masked events counted", irqSeen - base, 1);
    // R7: transient timer condition in idle mode is held
    cfgRx(1, 1, 1, 100, 1);
    doReset();
    base = irqSeen;
    maskIrq = 1'b1;
    events(0, 1); ticks(2); events(0, 1); idle(3);
    maskIrq = 1'b0; idle(3);
    check("R7", "transient held to unmask", irqSeen - base, 1);

    // R8: unmask restarts the delay
    cfgRx(1, 1, 2, 100, 0);
    doReset();
    base = irqSeen;
    maskIrq = 1'b1;
    ticks(3);
    maskIrq = 1'b0; idle(2);
    events(0, 1); ticks(1); idle(3);
    check("R8", "delay restarted at unmask", irqSeen - base, 0);
    ticks(3); idle(3);
    check("R8", "delay after unmask", irqSeen - base, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule